// File: doc/BRIEF.md
# Static Conditional-Branch Predictor

This block predicts, with fixed rules and without history tables or storage arrays, whether a conditional branch of an 8-bit accumulator-style processor will be taken. While decoding, the pipeline presents the current opcode, the signed 8-bit displacement and the address of the opcode. The block combines three things: which branch it is, whether the displacement points backward, and the opcode of the instruction that came just before it. From these it produces a taken/not-taken guess and the branch destination in the same cycle.

The block resolves the branch later, in operand fetch. The pipeline passes the branch back with the guess it acted on, and the ALU forwards its N, V, Z and C flags in that same cycle. The block works out the real outcome from these flags. When the outcome differs from the guess, it raises a one-cycle flush on the next clock, together with the address where fetch must resume. The preceding-opcode register is the only state in the predictor itself.

Top module: `bpred_static`

## Requirements
- R1: An opcode is a conditional branch exactly when its low five bits are 10000 (hex 10, 30, 50, 70, 90, B0, D0, F0). `pred_valid_o` is high only for a branch presented with `dec_valid_i` high. `pred_taken_o` is never high unless `pred_valid_o` is high.
- R2: When no rule below applies, a branch with a negative displacement (bit 7 set) is predicted taken and one with a positive displacement is predicted not taken.
- R3: After CLC (18), BCC (90) is predicted taken and BCS (B0) not taken. After SEC (38), BCS is taken and BCC not taken. After CLV (B8), BVC (50) is taken and BVS (70) not taken. These hold for either displacement sign.
- R4: After DEX (CA), DEY (88), INX (E8) or INY (C8), a backward BNE (D0) is predicted taken and a forward BNE is predicted not taken. A BEQ (F0) that follows these opcodes is predicted not taken in both directions.
- R5: After an immediate compare (C9, E0 or C0), a BEQ is predicted not taken in both directions.
- R6: `pred_target_o` equals the opcode address + 2 + the sign-extended displacement, modulo 2^16. It is computed for every opcode.
- R7: The preceding-opcode register loads `dec_opcode_i` only in cycles where `dec_valid_i` is high, and it clears to 00 on reset.
- R8: Bits 7:6 of the opcode select the flag under test (00 N, 01 V, 10 C, 11 Z). The branch is taken when that flag equals opcode bit 5. `res_flags_i` carries N, V, Z, C at bits 3, 2, 1, 0. `flush_o` is high in the cycle after a resolution branch whose real outcome differs from `res_pred_taken_i`, and is low otherwise. This includes cycles where `res_valid_i` is low or the opcode is not a branch.
- R9: With each flush, `flush_pc_o` gives the real next address: the branch destination when taken, the opcode address + 2 when not. It holds that value until the next flush.
- R10: Reset (active-low `rst_n`, asynchronous) drives `flush_o` low and `flush_pc_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | A valid instruction is in decode this cycle |
| dec_opcode_i | input | 8 | Opcode in decode |
| dec_offset_i | input | 8 | Signed branch displacement |
| dec_pc_i | input | 16 | Address of the opcode in decode |
| pred_valid_o | output | 1 | Decode holds a conditional branch |
| pred_taken_o | output | 1 | Branch predicted taken |
| pred_target_o | output | 16 | Destination if taken |
| res_valid_i | input | 1 | A branch is being resolved |
| res_opcode_i | input | 8 | Opcode of the resolving branch |
| res_pc_i | input | 16 | Address of the resolving branch |
| res_offset_i | input | 8 | Displacement of the resolving branch |
| res_pred_taken_i | input | 1 | Direction the front end followed |
| res_flags_i | input | 4 | Forwarded flags N, V, Z, C (bits 3..0) |
| flush_o | output | 1 | One-cycle mispredict flush |
| flush_pc_o | output | 16 | Address to resume fetch after a flush |

## Verification
A corrupted preceding-opcode register is visible at the ports on the very next decode of a branch. A branch with a flag-idiom or counter predecessor then returns the default direction-based guess, and the reverse can also happen. The bench therefore exposes the register with a CLC/BCS pair, where the two readings disagree. An error in the resolution logic appears one clock after `res_valid_i` as a missing, spurious or stretched `flush_o`, or as a wrong `flush_pc_o`. The bench samples both in that cycle and in the cycle after it.

// File: rtl/bpred_static.sv
module bpred_static #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid_i,
  input  logic [7:0]    dec_opcode_i,
  input  logic [OW-1:0] dec_offset_i,
  input  logic [AW-1:0] dec_pc_i,
  output logic          pred_valid_o,
  output logic          pred_taken_o,
  output logic [AW-1:0] pred_target_o,
  input  logic          res_valid_i,
  input  logic [7:0]    res_opcode_i,
  input  logic [AW-1:0] res_pc_i,
  input  logic [OW-1:0] res_offset_i,
  input  logic          res_pred_taken_i,
  input  logic [3:0]    res_flags_i,
  output logic          flush_o,
  output logic [AW-1:0] flush_pc_o
);

  localparam int EXT = AW - OW;

  function automatic logic [AW-1:0] dest(input logic [AW-1:0] pc, input logic [OW-1:0] off);
    return pc + AW'(2) + {{EXT{off[OW-1]}}, off};
  endfunction

  logic [7:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           prev_q <= 8'h00;
    else if (dec_valid_i) prev_q <= dec_opcode_i;

  wire       is_br    = dec_opcode_i[4:0] == 5'h10;
  wire [1:0] fsel     = dec_opcode_i[7:6];
  wire       want     = dec_opcode_i[5];
  wire       backward = dec_offset_i[OW-1];

  wire known_c = (prev_q == 8'h18) || (prev_q == 8'h38);
  wire c_val   = prev_q == 8'h38;
  wire known_v = prev_q == 8'hB8;
  wire counter = (prev_q == 8'hCA) || (prev_q == 8'h88) ||
                 (prev_q == 8'hE8) || (prev_q == 8'hC8);
  wire compare = (prev_q == 8'hC9) || (prev_q == 8'hE0) || (prev_q == 8'hC0);

  logic guess;
  always_comb begin
    if (fsel == 2'b10 && known_c)                guess = (c_val == want);
    else if (fsel == 2'b01 && known_v)           guess = !want;
    else if (fsel == 2'b11 && counter)           guess = !want && backward;
    else if (fsel == 2'b11 && compare && want)   guess = 1'b0;
    else                                         guess = backward;
  end

  assign pred_valid_o  = dec_valid_i && is_br;
  assign pred_taken_o  = pred_valid_o && guess;
  assign pred_target_o = dest(dec_pc_i, dec_offset_i);

  logic flag_sel;
  always_comb
    case (res_opcode_i[7:6])
      2'b00:   flag_sel = res_flags_i[3];
      2'b01:   flag_sel = res_flags_i[2];
      2'b10:   flag_sel = res_flags_i[0];
      default: flag_sel = res_flags_i[1];
    endcase

  wire res_br    = res_opcode_i[4:0] == 5'h10;
  wire res_taken = flag_sel == res_opcode_i[5];
  wire miss      = res_valid_i && res_br && (res_taken != res_pred_taken_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flush_o    <= 1'b0;
      flush_pc_o <= '0;
    end else begin
      flush_o <= miss;
      if (miss) flush_pc_o <= res_taken ? dest(res_pc_i, res_offset_i) : res_pc_i + AW'(2);
    end

endmodule

module bpred_static_chk #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid_i,
  input logic [7:0]    dec_opcode_i,
  input logic [OW-1:0] dec_offset_i,
  input logic          pred_valid_o,
  input logic          pred_taken_o,
  input logic          res_valid_i,
  input logic [7:0]    res_opcode_i,
  input logic [AW-1:0] res_pc_i,
  input logic [OW-1:0] res_offset_i,
  input logic          flush_o,
  input logic [AW-1:0] flush_pc_o,
  input logic [7:0]    prev_q
);

  assert_taken_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken_o |-> pred_valid_o);

  assert_nonbranch_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_opcode_i[4:0] != 5'h10) |-> !pred_valid_o);

  assert_clc_bcc_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_opcode_i == 8'h90 && prev_q == 8'h18) |-> pred_taken_o);

  assert_dex_bne_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_opcode_i == 8'hD0 && dec_offset_i[OW-1] && prev_q == 8'hCA) |-> pred_taken_o);

  assert_prev_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> $stable(prev_q));

  assert_prev_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> prev_q == $past(dec_opcode_i));

  assert_flush_needs_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> !flush_o);

  assert_flush_nonbranch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_i && res_opcode_i[4:0] != 5'h10) |=> !flush_o);

  assert_flush_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (flush_pc_o == $past(res_pc_i) + AW'(2) ||
                 flush_pc_o == $past(res_pc_i) + AW'(2) + {{(AW-OW){$past(res_offset_i[OW-1])}}, $past(res_offset_i)}));

  assert_flush_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |=> (flush_o || $stable(flush_pc_o)));

endmodule

bind bpred_static bpred_static_chk #(.AW(AW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i), .dec_opcode_i(dec_opcode_i),
  .dec_offset_i(dec_offset_i), .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
  .res_valid_i(res_valid_i), .res_opcode_i(res_opcode_i), .res_pc_i(res_pc_i),
  .res_offset_i(res_offset_i), .flush_o(flush_o), .flush_pc_o(flush_pc_o), .prev_q(prev_q)
);

// File: tb/bpred_static_tb.sv
module bpred_static_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dec_valid_i = 1'b0;
  logic [7:0] dec_opcode_i = '0, dec_offset_i = '0, res_opcode_i = '0, res_offset_i = '0;
  logic [15:0] dec_pc_i = '0, res_pc_i = '0;
  logic res_valid_i = 1'b0, res_pred_taken_i = 1'b0;
  logic [3:0] res_flags_i = '0;
  logic pred_valid_o, pred_taken_o, flush_o;
  logic [15:0] pred_target_o, flush_pc_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bpred_static dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i), .dec_opcode_i(dec_opcode_i),
    .dec_offset_i(dec_offset_i), .dec_pc_i(dec_pc_i), .pred_valid_o(pred_valid_o),
    .pred_taken_o(pred_taken_o), .pred_target_o(pred_target_o), .res_valid_i(res_valid_i),
    .res_opcode_i(res_opcode_i), .res_pc_i(res_pc_i), .res_offset_i(res_offset_i),
    .res_pred_taken_i(res_pred_taken_i), .res_flags_i(res_flags_i),
    .flush_o(flush_o), .flush_pc_o(flush_pc_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {prev, opcode, offset, pc, exp_valid, exp_taken, exp_target}
  localparam logic [57:0] VEC [16] = '{
    {8'hEA, 8'hD0, 8'hFC, 16'h1000, 1'b1, 1'b1, 16'h0FFE},  // R2 backward
    {8'hEA, 8'hD0, 8'h10, 16'h1000, 1'b1, 1'b0, 16'h1012},  // R2 forward
    {8'hCA, 8'hD0, 8'hFC, 16'h2000, 1'b1, 1'b1, 16'h1FFE},  // R4 DEX BNE back
    {8'hCA, 8'hD0, 8'h05, 16'h2000, 1'b1, 1'b0, 16'h2007},  // R4 DEX BNE fwd
    {8'h88, 8'hF0, 8'hFA, 16'h3000, 1'b1, 1'b0, 16'h2FFC},  // R4 DEY BEQ back
    {8'hC9, 8'hF0, 8'hF0, 16'h0400, 1'b1, 1'b0, 16'h03F2},  // R5 CMP BEQ back
    {8'h18, 8'h90, 8'h20, 16'h0500, 1'b1, 1'b1, 16'h0522},  // R3 CLC BCC fwd
    {8'h18, 8'hB0, 8'hF8, 16'h0500, 1'b1, 1'b0, 16'h04FA},  // R3 CLC BCS back
    {8'h38, 8'hB0, 8'h40, 16'h0600, 1'b1, 1'b1, 16'h0642},  // R3 SEC BCS fwd
    {8'hB8, 8'h50, 8'h7F, 16'h0700, 1'b1, 1'b1, 16'h0781},  // R3 CLV BVC fwd
    {8'hB8, 8'h70, 8'h80, 16'h0700, 1'b1, 1'b0, 16'h0682},  // R3 CLV BVS back
    {8'hEA, 8'hA9, 8'hFC, 16'h0800, 1'b0, 1'b0, 16'h07FE},  // R1 non-branch
    {8'hEA, 8'h10, 8'h7F, 16'hFFF0, 1'b1, 1'b0, 16'h0071},  // R6 wrap up
    {8'hEA, 8'h30, 8'h80, 16'h0010, 1'b1, 1'b1, 16'hFF92},  // R6 wrap down
    {8'hE8, 8'hD0, 8'hFE, 16'h1234, 1'b1, 1'b1, 16'h1234},  // R4 INX BNE back
    {8'hC9, 8'hD0, 8'h04, 16'h0100, 1'b1, 1'b0, 16'h0106}   // R2 CMP BNE fwd
  };

  task automatic present(input logic [7:0] op, input logic [7:0] off, input logic [15:0] pc);
    @(negedge clk);
    dec_valid_i = 1'b1; dec_opcode_i = op; dec_offset_i = off; dec_pc_i = pc;
    #1;
  endtask

  task automatic resolve(input string req, input logic [7:0] op, input logic [3:0] fl,
                         input logic [15:0] pc, input logic [7:0] off, input logic pt,
                         input logic v, input logic ef, input logic [15:0] epc);
    @(negedge clk);
    res_valid_i = v; res_opcode_i = op; res_flags_i = fl;
    res_pc_i = pc; res_offset_i = off; res_pred_taken_i = pt;
    @(negedge clk);
    res_valid_i = 1'b0;
    chk({req, " flush"}, flush_o, ef);
    chk({req, " flush_pc"}, flush_pc_o, epc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset flush", flush_o, 0);
    chk("R10 reset flush_pc", flush_pc_o, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      present(VEC[i][57:50], 8'h00, 16'h0000);
      present(VEC[i][49:42], VEC[i][41:34], VEC[i][33:18]);
      chk($sformatf("R1 vec%0d valid", i), pred_valid_o, VEC[i][17]);
      chk($sformatf("R2-rules vec%0d taken", i), pred_taken_o, VEC[i][16]);
      chk($sformatf("R6 vec%0d target", i), pred_target_o, VEC[i][15:0]);
    end

    // R1: valid strobe low suppresses prediction
    @(negedge clk); dec_valid_i = 1'b0; dec_opcode_i = 8'hD0; dec_offset_i = 8'hFC; #1;
    chk("R1 idle valid", pred_valid_o, 0);
    chk("R1 idle taken", pred_taken_o, 0);

    // R7: opcode seen while strobe low must not load
    present(8'hCA, 8'h00, 16'h0000);
    @(negedge clk); dec_valid_i = 1'b0; dec_opcode_i = 8'h18;
    present(8'hB0, 8'hF8, 16'h0500);
    chk("R7 hold on idle", pred_taken_o, 1);

    // R7: reset clears the previous opcode
    present(8'h18, 8'h00, 16'h0000);
    @(negedge clk); dec_valid_i = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    present(8'hB0, 8'hF8, 16'h0500);
    chk("R7 reset clear", pred_taken_o, 1);
    @(negedge clk); dec_valid_i = 1'b0;

    // R8/R9 resolution; flags {N,V,Z,C}
    resolve("R8 BNE Z0 pred0", 8'hD0, 4'b0000, 16'h2000, 8'hFC, 1'b0, 1'b1, 1'b1, 16'h1FFE);
    resolve("R8 BEQ Z1 pred1", 8'hF0, 4'b0010, 16'h2000, 8'hFC, 1'b1, 1'b1, 1'b0, 16'h1FFE);
    resolve("R9 BCC C1 pred1", 8'h90, 4'b0001, 16'h0500, 8'h20, 1'b1, 1'b1, 1'b1, 16'h0502);
    resolve("R9 BVS V1 pred0", 8'h70, 4'b0100, 16'h0700, 8'h10, 1'b0, 1'b1, 1'b1, 16'h0712);
    resolve("R8 BPL N1 pred0", 8'h10, 4'b1000, 16'h0900, 8'h10, 1'b0, 1'b1, 1'b0, 16'h0712);
    resolve("R8 nonbranch", 8'hA9, 4'b0000, 16'h0900, 8'h10, 1'b1, 1'b1, 1'b0, 16'h0712);
    resolve("R8 res idle", 8'hD0, 4'b0000, 16'h0900, 8'h10, 1'b0, 1'b0, 1'b0, 16'h0712);
    resolve("R8 BMI N1 pred0", 8'h30, 4'b1000, 16'h0040, 8'hF0, 1'b0, 1'b1, 1'b1, 16'h0032);
    @(negedge clk);
    chk("R8 pulse one cycle", flush_o, 0);
    chk("R9 pc holds", flush_pc_o, 16'h0032);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule